// File: doc/BRIEF.md
# Duty-Cycled Lock Status Sequencer

This block is the control sequencer of a low-power reference oscillator. It follows acquisition through a 4-bit status code and drives an unlock indicator for built-in test. It also produces the qualifiers that other logic uses to gate frequency steering, latching and disciplining. Each progress pulse from the acquisition logic moves the status one step closer to zero. A settling hold keeps the unlock indicator raised for a few seconds after the status first reaches zero. After that hold, a loss of lock or an alarm raises the indicator again at once.

In low-power mode the block runs in duty cycles. A wake timer starts when lock is reached. When it expires, the atomic section is powered down and the status shows a sleep code. When the sleep timer expires, power returns and acquisition starts again from the top. Both programmed times are raised to a floor when the programmed value is smaller. All timing is counted in pulses of a one-second tick input.

Top module: `ulp_lock_seq`

## Requirements
- R1: After reset, status is 8, unlock_ind is 1, atom_pwr is 1, and locked_q and disc_ok are 0.
- R2: While status is between 1 and 8, each acq_step pulse lowers status by exactly one. The pulse that takes status from 1 to 0 begins the settling hold.
- R3: unlock_ind is 1 whenever status is not 0.
- R4: After status reaches 0, unlock_ind stays 1 until HOLD_SECS (default 5) sec_tick pulses have been counted. It falls in the cycle after the clock edge that samples the last of those ticks.
- R5: Once status is 0, a lock_lost or alarm pulse sets status to 8 and unlock_ind to 1 in the next cycle. This takes priority over entry to sleep.
- R6: During acquisition, if STALL_SECS (default 20) sec_tick pulses arrive with no acq_step between them, status returns to 8.
- R7: With ulp_en set, the wake time is counted in ticks from the moment status reaches 0. When it runs out, the block enters sleep one cycle later: status 9, unlock_ind 1, atom_pwr 0. A programmed wake time below MIN_WAKE (default 10) is treated as MIN_WAKE.
- R8: Sleep lasts for the programmed sleep time, counted in ticks. A value below MIN_SLEEP (default 1800) is treated as MIN_SLEEP. One cycle after the last tick, status becomes 8 and atom_pwr becomes 1.
- R9: locked_q is 1 exactly when status is 0. This includes the settling hold.
- R10: disc_ok is 1 only when status is 0 and unlock_ind is 0. It is 0 during sleep, acquisition and the hold.
- R11: With ulp_en clear, the block never enters sleep, however long it stays locked. Clearing ulp_en during sleep ends sleep in the next cycle, with status 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ulp_en | input | 1 | Enables duty-cycled low-power operation |
| sleep_secs | input | CNT_W | Programmed sleep time in seconds |
| wake_secs | input | CNT_W | Programmed wake time in seconds |
| acq_step | input | 1 | Acquisition progress pulse |
| lock_lost | input | 1 | Loss-of-lock pulse |
| alarm | input | 1 | Alarm pulse |
| status | output | 4 | Acquisition status code (8..0, 9 = asleep) |
| unlock_ind | output | 1 | Unlock indicator for built-in test |
| atom_pwr | output | 1 | Power enable for the atomic section |
| locked_q | output | 1 | Qualifier for latch and steering commands |
| disc_ok | output | 1 | Disciplining allowed |

## Verification
Some rules hold on every cycle, and the assertions check these continuously:
- the unlock indicator is never low while status is nonzero;
- the qualifier outputs agree with status;
- power is off whenever the sleep code is shown;
- a progress pulse during acquisition always lowers status by exactly one;
- a loss or alarm while locked always restarts acquisition in the next cycle.

The timed windows can only be shown by the bench scenarios, because they depend on counting ticks from earlier events. These are the five-second hold, the stall restart, the clamped wake and sleep durations, and the effect of clearing low-power mode during sleep.

// File: rtl/ulp_lock_seq.sv
module ulp_lock_seq #(
  parameter int CNT_W      = 32,
  parameter int HOLD_SECS  = 5,
  parameter int STALL_SECS = 20,
  parameter int MIN_WAKE   = 10,
  parameter int MIN_SLEEP  = 1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             ulp_en,
  input  logic [CNT_W-1:0] sleep_secs,
  input  logic [CNT_W-1:0] wake_secs,
  input  logic             acq_step,
  input  logic             lock_lost,
  input  logic             alarm,
  output logic [3:0]       status,
  output logic             unlock_ind,
  output logic             atom_pwr,
  output logic             locked_q,
  output logic             disc_ok
);
  localparam int HW = $clog2(HOLD_SECS + 1);
  localparam int SW = $clog2(STALL_SECS + 1);
  localparam logic [3:0] ST_TOP   = 4'd8;
  localparam logic [3:0] ST_SLEEP = 4'd9;

  typedef enum logic [1:0] {P_ACQ, P_HOLD, P_RUN, P_SLEEP} phase_t;

  phase_t           phase;
  logic [3:0]       st;
  logic [CNT_W-1:0] tmr;
  logic [HW-1:0]    hcnt;
  logic [SW-1:0]    scnt;

  wire              fault   = lock_lost | alarm;
  wire [CNT_W-1:0]  wake_ld  = (wake_secs  < CNT_W'(MIN_WAKE))  ? CNT_W'(MIN_WAKE)  : wake_secs;
  wire [CNT_W-1:0]  sleep_ld = (sleep_secs < CNT_W'(MIN_SLEEP)) ? CNT_W'(MIN_SLEEP) : sleep_secs;
  wire [CNT_W-1:0]  tmr_dec  = (sec_tick && tmr != '0) ? tmr - 1'b1 : tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_ACQ;
      st    <= ST_TOP;
      tmr   <= '0;
      hcnt  <= '0;
      scnt  <= '0;
    end else begin
      case (phase)
        P_ACQ: begin
          if (acq_step) begin
            scnt <= '0;
            if (st == 4'd1) begin
              st    <= 4'd0;
              phase <= P_HOLD;
              hcnt  <= HW'(HOLD_SECS);
              tmr   <= wake_ld;
            end else begin
              st <= st - 4'd1;
            end
          end else if (sec_tick) begin
            if (scnt == SW'(STALL_SECS - 1)) begin
              st   <= ST_TOP;
              scnt <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        P_HOLD: begin
          if (fault) begin
            phase <= P_ACQ;
            st    <= ST_TOP;
            scnt  <= '0;
          end else if (sec_tick) begin
            tmr  <= tmr_dec;
            hcnt <= hcnt - 1'b1;
            if (hcnt == HW'(1)) phase <= P_RUN;
          end
        end
        P_RUN: begin
          if (fault) begin
            phase <= P_ACQ;
            st    <= ST_TOP;
            scnt  <= '0;
          end else if (ulp_en && tmr == '0) begin
            phase <= P_SLEEP;
            st    <= ST_SLEEP;
            tmr   <= sleep_ld;
          end else begin
            tmr <= tmr_dec;
          end
        end
        default: begin
          if (!ulp_en || tmr == '0) begin
            phase <= P_ACQ;
            st    <= ST_TOP;
            scnt  <= '0;
          end else begin
            tmr <= tmr_dec;
          end
        end
      endcase
    end
  end

  assign status     = st;
  assign unlock_ind = (phase != P_RUN);
  assign atom_pwr   = (phase != P_SLEEP);
  assign locked_q   = (phase == P_HOLD) || (phase == P_RUN);
  assign disc_ok    = (phase == P_RUN);
endmodule

// File: rtl/ulp_lock_seq_chk.sv
module ulp_lock_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acq_step,
  input logic       lock_lost,
  input logic       alarm,
  input logic [3:0] status,
  input logic       unlock_ind,
  input logic       atom_pwr,
  input logic       locked_q,
  input logic       disc_ok
);
  // R3
  unlock_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 4'd0) |-> unlock_ind);
  // R9
  latch_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q == (status == 4'd0));
  // R10
  disc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_ok |-> (!unlock_ind && status == 4'd0));
  // R7
  sleep_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd9) |-> !atom_pwr);
  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_step && status >= 4'd1 && status <= 4'd8) |=> (status == $past(status) - 4'd1));
  // R5
  fault_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd0 && (lock_lost || alarm)) |=> (status == 4'd8 && unlock_ind));
endmodule

bind ulp_lock_seq ulp_lock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acq_step(acq_step), .lock_lost(lock_lost), .alarm(alarm),
  .status(status), .unlock_ind(unlock_ind), .atom_pwr(atom_pwr),
  .locked_q(locked_q), .disc_ok(disc_ok)
);

// File: tb/ulp_lock_seq_bench.sv
`timescale 1ns/1ps
module ulp_lock_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0, ulp_en = 1'b0, acq_step = 1'b0, lock_lost = 1'b0, alarm = 1'b0;
  logic [31:0] sleep_secs = 32'd5, wake_secs = 32'd3;
  logic [3:0]  status;
  logic        unlock_ind, atom_pwr, locked_q, disc_ok;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ulp_lock_seq u_ulp_lock_seq (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ulp_en(ulp_en),
    .sleep_secs(sleep_secs), .wake_secs(wake_secs), .acq_step(acq_step),
    .lock_lost(lock_lost), .alarm(alarm), .status(status), .unlock_ind(unlock_ind),
    .atom_pwr(atom_pwr), .locked_q(locked_q), .disc_ok(disc_ok)
  );

  // [6] step, [5] tick, [4:1] expected status, [0] expected unlock
  localparam logic [6:0] VEC [13] = '{
    7'b1_0_0111_1, 7'b1_0_0110_1, 7'b1_0_0101_1, 7'b1_0_0100_1,
    7'b1_0_0011_1, 7'b1_0_0010_1, 7'b1_0_0001_1, 7'b1_0_0000_1,
    7'b0_1_0000_1, 7'b0_1_0000_1, 7'b0_1_0000_1, 7'b0_1_0000_1,
    7'b0_1_0000_0
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic t, input logic l, input logic a);
    @(negedge clk);
    acq_step = s; sec_tick = t; lock_lost = l; alarm = a;
    @(negedge clk);
    acq_step = 0; sec_tick = 0; lock_lost = 0; alarm = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(0, 1, 0, 0);
  endtask

  task automatic acquire();
    for (int i = 0; i < 8; i++) pulse(1, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 8);
    chk("R1 unlock", unlock_ind, 1);
    chk("R1 power", atom_pwr, 1);
    chk("R1 locked_q", locked_q, 0);
    chk("R1 disc_ok", disc_ok, 0);

    for (int i = 0; i < 13; i++) begin
      pulse(VEC[i][6], VEC[i][5], 0, 0);
      chk(VEC[i][6] ? "R2 status" : "R4 status", status, VEC[i][4:1]);
      chk(VEC[i][6] ? "R3 unlock" : "R4 unlock", unlock_ind, VEC[i][0]);
      if (i == 8) begin
        chk("R9 locked_q in hold", locked_q, 1);
        chk("R10 disc_ok in hold", disc_ok, 0);
      end
    end
    chk("R10 disc_ok locked", disc_ok, 1);

    ticks(40);
    chk("R11 no sleep status", status, 0);
    chk("R11 no sleep power", atom_pwr, 1);

    pulse(0, 0, 1, 0);
    chk("R5 loss status", status, 8);
    chk("R5 loss unlock", unlock_ind, 1);
    acquire();
    pulse(0, 0, 0, 1);
    chk("R5 alarm in hold", status, 8);
    acquire();
    ticks(5);
    chk("R4 relocked", unlock_ind, 0);
    pulse(0, 0, 0, 1);
    chk("R5 alarm locked", status, 8);
    chk("R9 locked_q after alarm", locked_q, 0);

    pulse(1, 0, 0, 0);
    ticks(19);
    chk("R6 before stall", status, 7);
    ticks(1);
    chk("R6 stall restart", status, 8);

    ulp_en = 1'b1;
    acquire();
    ticks(9);
    chk("R7 clamped wake not early", status, 0);
    ticks(1);
    @(negedge clk);
    chk("R7 sleep status", status, 9);
    chk("R7 sleep unlock", unlock_ind, 1);
    chk("R7 sleep power", atom_pwr, 0);
    chk("R10 disc_ok asleep", disc_ok, 0);

    ticks(1799);
    chk("R8 clamped sleep not early", status, 9);
    ticks(1);
    @(negedge clk);
    chk("R8 wake status", status, 8);
    chk("R8 wake power", atom_pwr, 1);

    acquire();
    ticks(10);
    @(negedge clk);
    chk("R7 second sleep", status, 9);
    ulp_en = 1'b0;
    @(negedge clk);
    chk("R11 exit sleep status", status, 8);
    chk("R11 exit sleep power", atom_pwr, 1);

    finish_run();
  end
endmodule